// File: doc/BRIEF.md
# Bus Slave Data Acknowledge Controller

This block drives the data-phase handshake of a slave on a processor bus. A transfer opens with a one-cycle start strobe. The burst flag and a transfer-type code are valid in that cycle. The block then answers the master with one acknowledge pulse for every data beat. A single transfer has one beat and a burst has four. The slave's storage reports through a ready input whether it can supply or accept the current beat. While ready is low, the current beat is stretched with wait states.

Some transfer-type codes cannot be served. When the error-enable bit is set at the start of such a transfer, the block ends that transfer with one error-acknowledge pulse and gives no data acknowledge. When the bit is clear, the same transfer completes with ordinary beats, so the master never hangs. The burst flag, the type code and the error-enable bit are all captured in the start cycle.

Both outputs come from registers. The earliest acknowledge is two clocks after the start strobe. A start strobe that arrives while a transfer is still open is dropped.

Top module: `bus_data_ack`

## Requirements
- R1: Both outputs are low while reset is asserted and stay low until a start strobe is accepted. A reset in the middle of a transfer abandons it, and no further pulses follow.
- R2: Cycle 0 is the cycle in which the start strobe is high. Neither output is high in cycle 0 or cycle 1. With ready held high, the first data acknowledge of a supported transfer is in cycle 2.
- R3: A transfer with burst flag 0 produces exactly one data acknowledge pulse. A transfer with burst flag 1 produces exactly four.
- R4: A beat completes only when ready is high in some cycle n, where n is 1 or later and the previous beat's acknowledge is not high in cycle n. Its acknowledge is then high in cycle n+1. While ready is low, no acknowledge is produced.
- R5: Each data acknowledge lasts one cycle, and at least one low cycle separates the beats of a burst.
- R6: Type codes 6 (3'b110) and 7 (3'b111) are unsupported. With error-enable at 1 in the start cycle, such a transfer gives exactly one error-acknowledge pulse in cycle 2, whatever ready does, and no data acknowledge.
- R7: With error-enable at 0 in the start cycle, an unsupported transfer completes like a supported one: normal data acknowledge beats and no error acknowledge.
- R8: A start strobe is ignored while a transfer is open. A strobe in the cycle that carries the final data acknowledge, or the error acknowledge, opens a new transfer.
- R9: The data acknowledge and the error acknowledge are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startStrobe | input | 1 | One-cycle transfer start |
| burstIn | input | 1 | 1 = four-beat burst, 0 = single beat; sampled with the start |
| xferType | input | TYPE_W | Transfer-type code; sampled with the start |
| resReady | input | 1 | Storage can complete the current beat in this cycle |
| errEnable | input | 1 | Enables error acknowledge for unsupported types; sampled with the start |
| ackOut | output | 1 | Per-beat data acknowledge, registered |
| errAckOut | output | 1 | Transfer error acknowledge, registered |

## Verification
The hardest case to reach is a start strobe in the exact cycle that another acknowledge occupies. In one variant it is a busy-period strobe that has to vanish. In the other it is a strobe on the closing pulse that has to be taken. The stimulus table gives every vector a per-cycle start pattern and a per-cycle ready pattern. A second strobe can therefore be placed in cycle 3 of a burst or in cycle 2 of a single or failing transfer. Ready patterns with gaps, and alternating ready patterns, push the beats away from the minimum spacing.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } ackState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture attributes of an accepted start
    logic leadStep;  // count down the minimum lead time
    logic beatFire;  // one data beat completes, acknowledge next cycle
    logic errFire;   // error acknowledge next cycle, transfer closed
  } strobe_t;

endpackage

// File: rtl/bus_ack_decode.sv
module bus_ack_decode #(
  parameter int TYPE_W = 3,
  parameter logic [2**TYPE_W-1:0] UNSUP_MASK = 8'hC0
) (
  input  logic [TYPE_W-1:0] xferType,
  output logic              unsupported
);
  localparam int NUM_CODES = 2**TYPE_W;

  logic [NUM_CODES-1:0] codeHit;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    assign codeHit[g] = UNSUP_MASK[g] && (xferType == TYPE_W'(g));
  end

  assign unsupported = |codeHit;
endmodule

// File: rtl/bus_ack_ctrl.sv
module bus_ack_ctrl
  import bus_ack_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStrobe,
  input  logic    resReady,
  input  logic    leadDone,
  input  logic    errPend,
  input  logic    lastBeat,
  input  logic    ackBusy,
  output strobe_t strb
);
  ackState_t state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (startStrobe) begin
          strb.load = 1'b1;
          stateNxt  = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (!leadDone) begin
          strb.leadStep = 1'b1;
        end else if (errPend) begin
          strb.errFire = 1'b1;
          stateNxt     = ST_IDLE;
        end else if (resReady && !ackBusy) begin
          strb.beatFire = 1'b1;
          if (lastBeat) stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/bus_ack_datapath.sv
module bus_ack_datapath
  import bus_ack_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int MIN_LEAD  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  logic    burstIn,
  input  logic    unsupIn,
  input  logic    errEnIn,
  output logic    leadDone,
  output logic    errPend,
  output logic    lastBeat,
  output logic    ackBusy,
  output logic    ackOut,
  output logic    errAckOut
);
  localparam int BEAT_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int LEAD_W    = (MIN_LEAD > 2) ? $clog2(MIN_LEAD) : 1;
  localparam int LEAD_INIT = MIN_LEAD - 2;

  logic              burstQ;
  logic              errPendQ;
  logic [LEAD_W-1:0] leadCnt;
  logic [BEAT_W-1:0] beatCnt;
  logic              ackQ;
  logic              errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstQ   <= 1'b0;
      errPendQ <= 1'b0;
      leadCnt  <= '0;
      beatCnt  <= '0;
    end else if (strb.load) begin
      burstQ   <= burstIn;
      errPendQ <= unsupIn && errEnIn;
      leadCnt  <= LEAD_W'(LEAD_INIT);
      beatCnt  <= '0;
    end else begin
      if (strb.leadStep) leadCnt <= leadCnt - LEAD_W'(1);
      if (strb.beatFire) beatCnt <= beatCnt + BEAT_W'(1);
      if (strb.errFire)  errPendQ <= 1'b0;
    end
  end

  // registered single-cycle pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackQ <= 1'b0;
      errQ <= 1'b0;
    end else begin
      ackQ <= strb.beatFire;
      errQ <= strb.errFire;
    end
  end

  assign leadDone  = (leadCnt == '0);
  assign errPend   = errPendQ;
  assign lastBeat  = burstQ ? (beatCnt == BEAT_W'(BURST_LEN - 1)) : 1'b1;
  assign ackBusy   = ackQ;
  assign ackOut    = ackQ;
  assign errAckOut = errQ;
endmodule

// File: rtl/bus_data_ack.sv
module bus_data_ack
  import bus_ack_pkg::*;
#(
  parameter int TYPE_W    = 3,
  parameter int BURST_LEN = 4,
  parameter int MIN_LEAD  = 2,
  parameter logic [2**TYPE_W-1:0] UNSUP_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic              burstIn,
  input  logic [TYPE_W-1:0] xferType,
  input  logic              resReady,
  input  logic              errEnable,
  output logic              ackOut,
  output logic              errAckOut
);
  strobe_t strb;
  logic    unsupported;
  logic    leadDone, errPend, lastBeat, ackBusy;

  bus_ack_decode #(.TYPE_W(TYPE_W), .UNSUP_MASK(UNSUP_MASK)) u_decode (
    .xferType   (xferType),
    .unsupported(unsupported)
  );

  bus_ack_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStrobe(startStrobe),
    .resReady   (resReady),
    .leadDone   (leadDone),
    .errPend    (errPend),
    .lastBeat   (lastBeat),
    .ackBusy    (ackBusy),
    .strb       (strb)
  );

  bus_ack_datapath #(.BURST_LEN(BURST_LEN), .MIN_LEAD(MIN_LEAD)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .burstIn  (burstIn),
    .unsupIn  (unsupported),
    .errEnIn  (errEnable),
    .leadDone (leadDone),
    .errPend  (errPend),
    .lastBeat (lastBeat),
    .ackBusy  (ackBusy),
    .ackOut   (ackOut),
    .errAckOut(errAckOut)
  );
endmodule

// File: rtl/bus_data_ack_chk.sv
module bus_data_ack_chk
  import bus_ack_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    resReady,
  input logic    ackOut,
  input logic    errAckOut,
  input strobe_t strb
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> (!ackOut && !errAckOut));

  assert_min_lead_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (!ackOut && !errAckOut));

  assert_ready_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(resReady));

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    errAckOut |=> !errAckOut);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ackOut && errAckOut));
endmodule

bind bus_data_ack bus_data_ack_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .resReady (resReady),
  .ackOut   (ackOut),
  .errAckOut(errAckOut),
  .strb     (strb)
);

// File: tb/bus_data_ack_tb.sv
module bus_data_ack_tb;
  localparam int WIN = 20;

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] startPat;
    logic        burst;
    logic [2:0]  xType;
    logic        errEn;
    logic [15:0] rdy;
    logic [15:0] expTa;
    logic [15:0] expTea;
  } vec_t;

  // bit i of a pattern = cycle i, cycle 0 = first start strobe
  localparam vec_t VECS [0:11] = '{
    '{4'd2, 16'h0001, 1'b0, 3'd0, 1'b1, 16'hFFFF, 16'h0004, 16'h0000}, // R2 single
    '{4'd3, 16'h0001, 1'b1, 3'd1, 1'b1, 16'hFFFF, 16'h0154, 16'h0000}, // R3 burst of four
    '{4'd4, 16'h0001, 1'b0, 3'd2, 1'b1, 16'hFFF0, 16'h0020, 16'h0000}, // R4 wait states
    '{4'd5, 16'h0001, 1'b1, 3'd3, 1'b1, 16'hFFF6, 16'h02A4, 16'h0000}, // R5 stretched beat
    '{4'd4, 16'h0001, 1'b1, 3'd3, 1'b1, 16'h5555, 16'h02A8, 16'h0000}, // R4 alternating
    '{4'd6, 16'h0001, 1'b0, 3'd6, 1'b1, 16'hFFFF, 16'h0000, 16'h0004}, // R6 code 6
    '{4'd6, 16'h0001, 1'b1, 3'd7, 1'b1, 16'h0000, 16'h0000, 16'h0004}, // R6 code 7, no ready
    '{4'd7, 16'h0001, 1'b1, 3'd6, 1'b0, 16'hFFFF, 16'h0154, 16'h0000}, // R7 burst
    '{4'd7, 16'h0001, 1'b0, 3'd7, 1'b0, 16'hFFF8, 16'h0010, 16'h0000}, // R7 single
    '{4'd8, 16'h0009, 1'b1, 3'd0, 1'b1, 16'hFFFF, 16'h0154, 16'h0000}, // R8 busy start dropped
    '{4'd8, 16'h0005, 1'b0, 3'd0, 1'b1, 16'hFFFF, 16'h0014, 16'h0000}, // R8 start on final ack
    '{4'd8, 16'h0005, 1'b0, 3'd6, 1'b1, 16'hFFFF, 16'h0000, 16'h0014}  // R8 start on error ack
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       startStrobe;
  logic       burstIn;
  logic [2:0] xferType;
  logic       resReady;
  logic       errEnable;
  logic       ackOut;
  logic       errAckOut;

  int checkCount = 0;
  int failCount  = 0;
  bit done       = 1'b0;

  always #10 clk = ~clk;

  bus_data_ack u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .startStrobe(startStrobe),
    .burstIn    (burstIn),
    .xferType   (xferType),
    .resReady   (resReady),
    .errEnable  (errEnable),
    .ackOut     (ackOut),
    .errAckOut  (errAckOut)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runVec(input int idx);
    vec_t v;
    logic [WIN-1:0] obsTa, obsTea;
    v = VECS[idx];
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      obsTa[i]    = ackOut;
      obsTea[i]   = errAckOut;
      startStrobe = (i < 16) ? v.startPat[i] : 1'b0;
      resReady    = (i < 16) ? v.rdy[i] : 1'b1;
      burstIn     = v.burst;
      xferType    = v.xType;
      errEnable   = v.errEn;
    end
    check(obsTa == {4'b0, v.expTa}, $sformatf("R%0d vec%0d ack", v.req, idx),
          32'(obsTa), 32'({4'b0, v.expTa}));
    check(obsTea == {4'b0, v.expTea}, $sformatf("R%0d vec%0d err", v.req, idx),
          32'(obsTea), 32'({4'b0, v.expTea}));
    check((obsTa & obsTea) == '0, $sformatf("R9 vec%0d overlap", idx),
          32'(obsTa & obsTea), 32'd0);
  endtask

  initial begin
    logic [15:0] seen;
    rstN = 1'b0; startStrobe = 1'b0; burstIn = 1'b0; xferType = '0;
    resReady = 1'b1; errEnable = 1'b1;
    repeat (3) @(negedge clk);
    check(!ackOut && !errAckOut, "R1 in reset", {30'b0, ackOut, errAckOut}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!ackOut && !errAckOut, "R1 idle after reset", {30'b0, ackOut, errAckOut}, 32'd0);

    for (int k = 0; k < 12; k++) runVec(k);

    // R1: reset in the middle of a burst
    seen = '0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      seen[i] = ackOut;
      startStrobe = (i == 0);
      burstIn = 1'b1; xferType = 3'd0; errEnable = 1'b1; resReady = 1'b1;
    end
    check(seen[5:0] == 6'b010100, "R1 pre-reset beats", 32'(seen[5:0]), 32'b010100);
    rstN = 1'b0;
    @(negedge clk);
    check(!ackOut && !errAckOut, "R1 mid-transfer reset", {30'b0, ackOut, errAckOut}, 32'd0);
    rstN = 1'b1;
    seen = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      seen[i] = ackOut | errAckOut;
    end
    check(seen == '0, "R1 abandoned transfer", 32'(seen), 32'd0);

    // R3: fresh single transfer after the reset
    runVec(0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule